// File: doc/BRIEF.md
# Top-of-Stack Register Cache

This block is the evaluation-stack front end of a stack processor. The topmost stack words sit in a small circular array of physical registers. When the stack grows or shrinks, a rotating top index relabels which register holds the top, so no data is ever copied between registers. The core issues push, pop, binary-operate and peek commands. A peek reads the entry k places below the top without removing anything. An operate command takes the two topmost entries and leaves one result in their place.

Behind the register array sits a backing memory, reached through a single-word request/acknowledge port. Transfers run in the background, one word per acknowledged transaction:

- When occupancy reaches three quarters of the array, the oldest resident word is written out. Spilled words go to ascending addresses starting at 0.
- When occupancy drops to one quarter and memory still holds words, the most recently spilled word is read back in below the current bottom.
- A command that needs an entry that is not resident stalls and forces a fill.
- A push into a full array stalls until a spill frees a slot.
- Removing more entries than the whole stack holds sets a sticky error flag and changes nothing else.

Top module: `tos_cache`

## Requirements
- R1: After reset the occupancy is 0, the error flag is 0, no memory request is raised, no read result is flagged valid, and an idle command (op 0) sees ready high.
- R2: Push (op 1) places cmd_data on top. Pop (op 2) removes the top entry, and its value appears on rd_data with rd_valid high in the cycle after acceptance. Values come back in last-in-first-out order.
- R3: Operate (op 3) replaces the two topmost entries with one result computed from the entry below the top (A) and the top (B). Function code 0 gives A+B, 1 gives A-B, 2 gives A AND B and 3 gives A XOR B. Occupancy drops by one.
- R4: Peek (op 4) with depth k returns the entry k places below the top (k=0 is the top) on rd_data in the cycle after acceptance, and leaves occupancy and the top unchanged.
- R5: While no transfer is pending and occupancy is at least 3/4 of DEPTH, the oldest resident word is written to memory. Spills go to ascending addresses from 0, oldest word first, and stop once occupancy falls below the mark.
- R6: While no transfer is pending, memory holds words and occupancy is at most DEPTH/4, the word at the highest spilled address is read back below the bottom. Background filling stops at DEPTH/4+1 entries.
- R7: A push is not accepted while the array is full, or while a pending fill holds the last free slot.
- R8: A pop, operate or peek whose entries are not all resident, while the whole stack holds enough words, stalls and triggers fills until they are resident. It then completes with the correct value.
- R9: A pop on a stack holding no words, an operate on a stack holding fewer than two, or a peek with k at or beyond the total depth is accepted. It sets a sticky error flag, produces no read result and leaves the occupancy unchanged.
- R10: A memory request keeps address, direction and write data stable until acknowledged, and each acknowledge moves exactly one word.
- R11: Occupancy never exceeds DEPTH, and it does not change in a cycle with no command and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | 0 idle, 1 push, 2 pop, 3 operate, 4 peek |
| cmd_fn | input | 2 | Operate function: 0 add, 1 subtract, 2 and, 3 xor |
| cmd_data | input | W | Value to push |
| cmd_depth | input | IW | Peek depth below the top |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| top_data | output | W | Current top entry |
| rd_valid | output | 1 | Pop or peek result present |
| rd_data | output | W | Pop or peek result |
| res_count | output | IW+1 | Number of resident entries |
| underflow_err | output | 1 | Sticky underflow flag |
| mem_req | output | 1 | Memory transfer pending |
| mem_we | output | 1 | 1 spill write, 0 fill read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | W | Spill data |
| mem_ack | input | 1 | One-cycle transfer acknowledge |
| mem_rdata | input | W | Fill data, valid with mem_ack |

## Verification
The checks assume that mem_ack rises only while mem_req is high, lasts a single cycle, and carries fill data in that same cycle. They also assume a peek depth always fits below DEPTH. The bench memory model answers only a pending request, after a chosen latency, with a one-cycle acknowledge. All commands are driven on the falling edge and held until the cycle in which cmd_ready is seen high. Latencies are varied from short to long so that both the background watermark transfers and the full-array and demand-fill stalls are reached.

// File: rtl/tos_pkg.sv
package tos_pkg;
    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_ALU  = 3'd3,
        OP_PEEK = 3'd4
    } tos_op_e;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_AND = 2'd2,
        FN_XOR = 2'd3
    } tos_fn_e;
endpackage

// File: rtl/tos_regfile.sv
// Circular register array: never shifted, only indexed.
module tos_regfile #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int NRD   = 4,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wa_en,
    input  logic [IW-1:0]            wa_idx,
    input  logic [W-1:0]             wa_val,
    input  logic                     wb_en,
    input  logic [IW-1:0]            wb_idx,
    input  logic [W-1:0]             wb_val,
    input  logic [NRD-1:0][IW-1:0]   rd_idx,
    output logic [NRD-1:0][W-1:0]    rd_word
);
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wa_en) mem_d[wa_idx] = wa_val;
        if (wb_en) mem_d[wb_idx] = wb_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '{default: '0};
        else        mem_q <= mem_d;
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_word[r] = mem_q[rd_idx[r]];
    end
endmodule

// File: rtl/tos_alu.sv
module tos_alu
    import tos_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_below,
    input  logic [W-1:0] b_top,
    input  logic [1:0]   fn,
    output logic [W-1:0] result
);
    always_comb begin
        unique case (tos_fn_e'(fn))
            FN_ADD:  result = a_below + b_top;
            FN_SUB:  result = a_below - b_top;
            FN_AND:  result = a_below & b_top;
            default: result = a_below ^ b_top;
        endcase
    end
endmodule

// File: rtl/tos_xfer.sv
// One-word-at-a-time spill/fill engine; owns the memory stack pointer.
module tos_xfer #(
    parameter int W  = 16,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_spill,
    input  logic          start_fill,
    input  logic [W-1:0]  spill_word,
    input  logic          mem_ack,
    output logic          busy,
    output logic          is_fill,
    output logic          done_spill,
    output logic          done_fill,
    output logic [AW-1:0] mem_depth,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [W-1:0]  mem_wdata
);
    typedef struct packed {
        logic          busy;
        logic          we;
        logic [AW-1:0] addr;
        logic [W-1:0]  wdata;
        logic [AW-1:0] msp;
    } xfer_t;

    xfer_t x_q, x_d;

    always_comb begin
        x_d = x_q;
        if (!x_q.busy) begin
            if (start_spill) begin
                x_d.busy  = 1'b1;
                x_d.we    = 1'b1;
                x_d.addr  = x_q.msp;
                x_d.wdata = spill_word;
            end else if (start_fill) begin
                x_d.busy  = 1'b1;
                x_d.we    = 1'b0;
                x_d.addr  = x_q.msp - AW'(1);
            end
        end else if (mem_ack) begin
            x_d.busy = 1'b0;
            if (x_q.we) x_d.msp = x_q.msp + AW'(1);
            else        x_d.msp = x_q.msp - AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) x_q <= '0;
        else        x_q <= x_d;
    end

    assign busy       = x_q.busy;
    assign is_fill    = x_q.busy & ~x_q.we;
    assign done_spill = x_q.busy & x_q.we & mem_ack;
    assign done_fill  = x_q.busy & ~x_q.we & mem_ack;
    assign mem_depth  = x_q.msp;
    assign mem_req    = x_q.busy;
    assign mem_we     = x_q.we;
    assign mem_addr   = x_q.addr;
    assign mem_wdata  = x_q.wdata;
endmodule

// File: rtl/tos_cache.sv
module tos_cache
    import tos_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int AW    = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [1:0]    cmd_fn,
    input  logic [W-1:0]  cmd_data,
    input  logic [IW-1:0] cmd_depth,
    output logic          cmd_ready,
    output logic [W-1:0]  top_data,
    output logic          rd_valid,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] res_count,
    output logic          underflow_err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [W-1:0]  mem_wdata,
    input  logic          mem_ack,
    input  logic [W-1:0]  mem_rdata
);
    localparam int HI_MARK = (3 * DEPTH) / 4;
    localparam int LO_MARK = DEPTH / 4;
    localparam int NRD     = 4;

    typedef struct packed {
        logic [IW-1:0] top;
        logic [CW-1:0] res;
        logic          err;
        logic          rdv;
        logic [W-1:0]  rdd;
    } core_t;

    core_t s_q, s_d;

    tos_op_e op;
    assign op = tos_op_e'(cmd_op);

    logic [NRD-1:0][IW-1:0] rd_idx;
    logic [NRD-1:0][W-1:0]  rd_word;
    logic                   wa_en, wb_en;
    logic [IW-1:0]          wa_idx, wb_idx;
    logic [W-1:0]           wa_val, wb_val;
    logic [W-1:0]           alu_out;

    logic          x_busy, x_fill, x_done_spill, x_done_fill;
    logic [AW-1:0] x_depth;
    logic          start_spill, start_fill;

    logic [AW:0]   total;
    logic [CW-1:0] eff_res;
    logic          spill_busy, fill_busy;
    logic          has_room;
    logic          bad_cmd, ok_cmd, want_fill, fire;
    logic [1:0]    n_up, n_dn;

    // Physical slots addressed relative to the rotating top index.
    assign rd_idx[0] = s_q.top;
    assign rd_idx[1] = s_q.top - IW'(1);
    assign rd_idx[2] = s_q.top - cmd_depth;
    assign rd_idx[3] = s_q.top - s_q.res[IW-1:0] + IW'(1);

    tos_regfile #(.W(W), .DEPTH(DEPTH), .NRD(NRD)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wa_en   (wa_en),
        .wa_idx  (wa_idx),
        .wa_val  (wa_val),
        .wb_en   (wb_en),
        .wb_idx  (wb_idx),
        .wb_val  (wb_val),
        .rd_idx  (rd_idx),
        .rd_word (rd_word)
    );

    tos_alu #(.W(W)) u_alu (
        .a_below (rd_word[1]),
        .b_top   (rd_word[0]),
        .fn      (cmd_fn),
        .result  (alu_out)
    );

    tos_xfer #(.W(W), .AW(AW)) u_xfer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_spill (start_spill),
        .start_fill  (start_fill),
        .spill_word  (rd_word[3]),
        .mem_ack     (mem_ack),
        .busy        (x_busy),
        .is_fill     (x_fill),
        .done_spill  (x_done_spill),
        .done_fill   (x_done_fill),
        .mem_depth   (x_depth),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata)
    );

    // Command admission: residency, room and underflow.
    always_comb begin
        total      = (AW+1)'(s_q.res) + (AW+1)'(x_depth);
        spill_busy = x_busy & ~x_fill;
        fill_busy  = x_fill;
        // The word being spilled is not available for removal.
        eff_res    = s_q.res - CW'(spill_busy);
        // A pending fill has claimed one free slot.
        has_room   = (s_q.res + CW'(fill_busy)) < CW'(DEPTH);
        bad_cmd    = 1'b0;
        ok_cmd     = 1'b1;
        want_fill  = 1'b0;
        unique case (op)
            OP_PUSH: ok_cmd = has_room;
            OP_POP: begin
                bad_cmd = (total == '0);
                ok_cmd  = bad_cmd || (eff_res >= CW'(1));
            end
            OP_ALU: begin
                bad_cmd = (total < (AW+1)'(2));
                ok_cmd  = bad_cmd || (eff_res >= CW'(2));
            end
            OP_PEEK: begin
                bad_cmd = (total <= (AW+1)'(cmd_depth));
                ok_cmd  = bad_cmd || (CW'(cmd_depth) < s_q.res);
            end
            default: ;
        endcase
        if (cmd_valid && !ok_cmd && op != OP_PUSH) want_fill = 1'b1;
        fire = cmd_valid && ok_cmd;
    end

    // Watermark and demand triggers for the transfer engine.
    always_comb begin
        start_fill  = !x_busy && (x_depth != '0) && (s_q.res < CW'(DEPTH)) &&
                      ((s_q.res <= CW'(LO_MARK)) || want_fill);
        start_spill = !x_busy && (s_q.res >= CW'(HI_MARK)) && !want_fill;
    end

    // Next state of the core-side registers.
    always_comb begin
        s_d    = s_q;
        s_d.rdv = 1'b0;
        wa_en  = 1'b0;
        wa_idx = s_q.top + IW'(1);
        wa_val = cmd_data;
        wb_en  = 1'b0;
        wb_idx = s_q.top - s_q.res[IW-1:0];
        wb_val = mem_rdata;
        n_up   = 2'd0;
        n_dn   = 2'd0;
        if (fire) begin
            if (bad_cmd) begin
                s_d.err = 1'b1;
            end else begin
                unique case (op)
                    OP_PUSH: begin
                        s_d.top = s_q.top + IW'(1);
                        wa_en   = 1'b1;
                        n_up    = n_up + 2'd1;
                    end
                    OP_POP: begin
                        s_d.top = s_q.top - IW'(1);
                        s_d.rdv = 1'b1;
                        s_d.rdd = rd_word[0];
                        n_dn    = n_dn + 2'd1;
                    end
                    OP_ALU: begin
                        s_d.top = s_q.top - IW'(1);
                        wa_en   = 1'b1;
                        wa_idx  = s_q.top - IW'(1);
                        wa_val  = alu_out;
                        n_dn    = n_dn + 2'd1;
                    end
                    OP_PEEK: begin
                        s_d.rdv = 1'b1;
                        s_d.rdd = rd_word[2];
                    end
                    default: ;
                endcase
            end
        end
        if (x_done_spill) n_dn = n_dn + 2'd1;
        if (x_done_fill) begin
            wb_en = 1'b1;
            n_up  = n_up + 2'd1;
        end
        s_d.res = s_q.res + CW'(n_up) - CW'(n_dn);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_ready     = ok_cmd;
    assign top_data      = rd_word[0];
    assign rd_valid      = s_q.rdv;
    assign rd_data       = s_q.rdd;
    assign res_count     = s_q.res;
    assign underflow_err = s_q.err;
endmodule

// File: rtl/tos_cache_chk.sv
module tos_cache_chk #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int AW    = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = IW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic          cmd_ready,
    input logic [CW-1:0] res_count,
    input logic          underflow_err,
    input logic          rd_valid,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [W-1:0]  mem_wdata,
    input logic          mem_ack
);
    localparam int HI_MARK = (3 * DEPTH) / 4;

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    assert_occ_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res_count <= CW'(DEPTH));

    assert_occ_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid && !mem_ack |=> $stable(res_count));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err);

    assert_full_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == 3'd1 && res_count == CW'(DEPTH) |-> !cmd_ready);

    assert_spill_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) && mem_we |-> $past(res_count) >= CW'(HI_MARK));

    assert_fill_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) && !mem_we |-> $past(res_count) < CW'(DEPTH));

    assert_rd_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_valid && cmd_ready && (cmd_op == 3'd2 || cmd_op == 3'd4)));

    assert_peek_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_op == 3'd4 && !mem_ack |=> $stable(res_count));
endmodule

bind tos_cache tos_cache_chk #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_ready     (cmd_ready),
    .res_count     (res_count),
    .underflow_err (underflow_err),
    .rd_valid      (rd_valid),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ack       (mem_ack)
);

// File: tb/tos_cache_tb.sv
module tos_cache_tb;
    localparam int W = 16;
    localparam int DEPTH = 8;
    localparam int AW = 8;
    localparam int IW = 3;
    localparam int CW = 4;

    localparam logic [2:0] C_IDLE = 3'd0, C_PUSH = 3'd1, C_POP = 3'd2,
                           C_ALU = 3'd3, C_PEEK = 3'd4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = C_IDLE;
    logic [1:0]    cmd_fn = 2'd0;
    logic [W-1:0]  cmd_data = '0;
    logic [IW-1:0] cmd_depth = '0;
    logic          cmd_ready;
    logic [W-1:0]  top_data;
    logic          rd_valid;
    logic [W-1:0]  rd_data;
    logic [CW-1:0] res_count;
    logic          underflow_err;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [W-1:0]  mem_wdata;
    logic          mem_ack = 1'b0;
    logic [W-1:0]  mem_rdata = '0;

    always #10 clk = ~clk;

    tos_cache #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_fn(cmd_fn), .cmd_data(cmd_data), .cmd_depth(cmd_depth),
        .cmd_ready(cmd_ready), .top_data(top_data), .rd_valid(rd_valid),
        .rd_data(rd_data), .res_count(res_count), .underflow_err(underflow_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int total_n = 0;
    int bad_n = 0;
    bit finished = 1'b0;

    // Backing memory model, acting on the falling edge.
    logic [W-1:0] bmem [256];
    int lat = 2;
    int cnt = 0;
    int wr_cnt = 0;
    int wr_order_bad = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            cnt = 0;
            wr_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
            cnt = 0;
        end else if (mem_req) begin
            cnt = cnt + 1;
            if (cnt >= lat) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    bmem[mem_addr] = mem_wdata;
                    if (int'(mem_addr) != wr_cnt) wr_order_bad = wr_order_bad + 1;
                    wr_cnt = wr_cnt + 1;
                end else begin
                    mem_rdata = bmem[mem_addr];
                end
            end
        end
    end

    logic         last_rdv;
    logic [W-1:0] last_rd;
    bit           saw_full_stall = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total_n++;
        if (act !== exp) begin
            bad_n++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [W-1:0] data,
                          input logic [1:0] fn, input logic [IW-1:0] k, output int waited);
        waited = 0;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = op;
        cmd_data = data;
        cmd_fn = fn;
        cmd_depth = k;
        #1;
        while (!cmd_ready) begin
            if (op == C_PUSH && res_count == CW'(DEPTH)) saw_full_stall = 1'b1;
            waited++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op = C_IDLE;
        last_rdv = rd_valid;
        last_rd = rd_data;
    endtask

    task automatic push(input logic [W-1:0] v);
        int w;
        do_cmd(C_PUSH, v, 2'd0, '0, w);
    endtask

    task automatic pop_expect(input string req, input logic [W-1:0] v);
        int w;
        do_cmd(C_POP, '0, 2'd0, '0, w);
        check({req, " pop valid"}, 32'(last_rdv), 32'd1);
        check({req, " pop value"}, 32'(last_rd), 32'(v));
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 occupancy", 32'(res_count), 32'd0);
        check("R1 error", 32'(underflow_err), 32'd0);
        check("R1 mem_req", 32'(mem_req), 32'd0);
        check("R1 rd_valid", 32'(rd_valid), 32'd0);
        check("R1 ready", 32'(cmd_ready), 32'd1);
    endtask

    task automatic t_push_pop();
        lat = 2;
        do_reset();
        push(16'h0011);
        push(16'h0022);
        push(16'h0033);
        check("R2 top", 32'(top_data), 32'h33);
        check("R11 occupancy", 32'(res_count), 32'd3);
        pop_expect("R2", 16'h0033);
        pop_expect("R2", 16'h0022);
        check("R11 occupancy after pops", 32'(res_count), 32'd1);
        pop_expect("R2", 16'h0011);
        check("R2 empty", 32'(res_count), 32'd0);
    endtask

    task automatic t_alu();
        int w;
        do_reset();
        push(16'd10);
        push(16'd3);
        do_cmd(C_ALU, '0, 2'd1, '0, w);
        check("R3 sub", 32'(top_data), 32'd7);
        check("R3 occupancy", 32'(res_count), 32'd1);
        push(16'd5);
        do_cmd(C_ALU, '0, 2'd0, '0, w);
        check("R3 add", 32'(top_data), 32'd12);
        push(16'h000F);
        do_cmd(C_ALU, '0, 2'd2, '0, w);
        check("R3 and", 32'(top_data), 32'd12);
        push(16'd12);
        do_cmd(C_ALU, '0, 2'd3, '0, w);
        check("R3 xor", 32'(top_data), 32'd0);
        check("R3 final occupancy", 32'(res_count), 32'd1);
    endtask

    task automatic t_peek();
        int w;
        do_reset();
        push(16'h00A1);
        push(16'h00A2);
        push(16'h00A3);
        for (int k = 0; k < 3; k++) begin
            do_cmd(C_PEEK, '0, 2'd0, IW'(k), w);
            check("R4 peek valid", 32'(last_rdv), 32'd1);
            check("R4 peek value", 32'(last_rd), 32'(16'h00A3 - 16'(k)));
        end
        check("R4 occupancy kept", 32'(res_count), 32'd3);
        check("R4 top kept", 32'(top_data), 32'hA3);
    endtask

    task automatic t_spill_fill();
        int w;
        lat = 3;
        do_reset();
        wr_order_bad = 0;
        for (int i = 0; i < 12; i++) push(16'h0100 + 16'(i));
        idle(100);
        check("R5 occupancy settles below mark", 32'(res_count), 32'd5);
        check("R5 words spilled", 32'(wr_cnt), 32'd7);
        check("R10 ascending write order", 32'(wr_order_bad), 32'd0);
        for (int i = 0; i < 7; i++)
            check("R5 spilled content", 32'(bmem[i]), 32'(16'h0100 + 16'(i)));
        do_cmd(C_PEEK, '0, 2'd0, IW'(4), w);
        check("R5 oldest resident", 32'(last_rd), 32'h107);
        pop_expect("R6", 16'h010B);
        pop_expect("R6", 16'h010A);
        pop_expect("R6", 16'h0109);
        idle(50);
        check("R6 fill stops above quarter", 32'(res_count), 32'd3);
        do_cmd(C_PEEK, '0, 2'd0, IW'(2), w);
        check("R6 filled word placed below bottom", 32'(last_rd), 32'h106);
        for (int i = 8; i >= 0; i--) pop_expect("R8", 16'h0100 + 16'(i));
        check("R8 drained", 32'(res_count), 32'd0);
        check("R8 no error", 32'(underflow_err), 32'd0);
    endtask

    task automatic t_demand();
        int w;
        lat = 4;
        do_reset();
        for (int i = 0; i < 8; i++) push(16'h0200 + 16'(i));
        idle(100);
        check("R5 settled", 32'(res_count), 32'd5);
        do_cmd(C_PEEK, '0, 2'd0, IW'(6), w);
        check("R8 peek stalled", 32'(w > 0), 32'd1);
        check("R8 deep peek value", 32'(last_rd), 32'h201);
        idle(100);
        check("R8 occupancy returns", 32'(res_count), 32'd5);
    endtask

    task automatic t_full_stall();
        lat = 12;
        do_reset();
        saw_full_stall = 1'b0;
        for (int i = 0; i < 12; i++) push(16'h0300 + 16'(i));
        check("R7 push stalled on full array", 32'(saw_full_stall), 32'd1);
        idle(150);
        for (int i = 11; i >= 0; i--) pop_expect("R7", 16'h0300 + 16'(i));
    endtask

    task automatic t_underflow();
        int w;
        lat = 2;
        do_reset();
        do_cmd(C_POP, '0, 2'd0, '0, w);
        check("R9 pop empty sets error", 32'(underflow_err), 32'd1);
        check("R9 pop empty no result", 32'(last_rdv), 32'd0);
        check("R9 pop empty occupancy", 32'(res_count), 32'd0);
        do_reset();
        push(16'h0055);
        do_cmd(C_ALU, '0, 2'd0, '0, w);
        check("R9 short operate sets error", 32'(underflow_err), 32'd1);
        check("R9 short operate occupancy", 32'(res_count), 32'd1);
        check("R9 short operate top", 32'(top_data), 32'h55);
        do_cmd(C_PEEK, '0, 2'd0, IW'(1), w);
        check("R9 deep peek no result", 32'(last_rdv), 32'd0);
        idle(3);
        check("R9 error sticky", 32'(underflow_err), 32'd1);
    endtask

    initial begin
        t_reset();
        t_push_pop();
        t_alu();
        t_peek();
        t_spill_fill();
        t_demand();
        t_full_stall();
        t_underflow();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total_n, bad_n);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total_n++;
            bad_n++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total_n, bad_n);
            $finish;
        end
    end
endmodule